// File: doc/BRIEF.md
# Lead/Lag Successive-Approximation Bias Trim Controller

This block sets a 4-bit trim code for an external bias DAC in a charge-pump phase-locked loop. The code is tuned until the up and down pump currents match. The only measurement it uses is one polarity bit. A D flip-flop clocked by the reference clock samples the feedback clock level on each reference rising edge. A low sample means the feedback edge has not arrived yet, so the reference leads and the phase error is positive. A high sample means the reference lags.

The controller has three modes:
- **Coarse:** the loop is still acquiring lock. The code is held at all ones, which puts the DAC output at the supply.
- **Tracking:** entered once the lock flag rises. A binary search moves downward from all ones and takes one step every sixteen reference cycles. At each step it first settles the previous trial bit from the sampled polarity, then clears the next lower bit as the new trial.
- **Hold:** after the fourth step the code is frozen and a done flag is raised.

A falling lock flag in any mode sends the block back to the coarse state.

All logic runs on the reference clock. The asynchronous reset is released through a two-stage synchronizer.

Top module: `sar_trim_ctrl`

## Requirements
- R1: While reset is asserted and after its release, until lock is seen, trim_code_o is 4'b1111 and busy_o and done_o are 0.
- R2: While locked_i is 0, trim_code_o stays 4'b1111 and busy_o and done_o stay 0, whatever the feedback clock does.
- R3: On the first rising edge of ref_clk with locked_i at 1 in the coarse state, busy_o rises. Exactly 16 rising edges later, the MSB is cleared and trim_code_o becomes 4'b0111.
- R4: While in tracking, trim_code_o changes only on every 16th rising edge of ref_clk. It is stable on all other edges.
- R5: On the 2nd to 4th steps, the previous trial bit (index 4 minus step number plus 1) is first set back to 1 if the polarity is negative. The polarity is negative when fb_clk is high at the ref_clk rising edge. The bit stays 0 if the polarity is positive, which is fb_clk low at that edge. The next lower bit is then cleared.
- R6: With polarity positive, negative, positive at steps 2, 3 and 4, the code goes 1111, 0111, 0011, 0101, 0100.
- R7: After the 4th step, done_o is 1 and busy_o is 0, and bit 0 keeps its trial value of 0. The code then stays frozen for as long as locked_i stays 1.
- R8: When locked_i is 0 at a rising edge of ref_clk in any mode, the next outputs are trim_code_o = 4'b1111, busy_o = 0 and done_o = 0. A later lock restarts the full 16-cycle timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock. Clocks all state and the lead/lag sampler. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| fb_clk | input | 1 | Divided feedback clock, sampled as data on ref_clk rising edges. |
| locked_i | input | 1 | Lock-detected flag, synchronous to ref_clk. |
| trim_code_o | output | 4 | Trim code to the bias DAC. All ones means the DAC output is at the supply. |
| busy_o | output | 1 | High while the search is running. |
| done_o | output | 1 | High while the final code is held. |

## Verification
A bad mode or step-pointer state shows up on busy_o/done_o or as a code change one edge too early or late, and is visible 16 cycles after the lock rises. A misjudged trial bit leaves a wrong code at the next step and a wrong final code four steps later. The bench checks each step against a model, so the error is reported at the step where it first appears. A stale or inverted polarity path shows up as the wrong branch at step 2 for targets near a bit boundary.

// File: rtl/sar_trim_pkg.sv
package sar_trim_pkg;
  typedef enum logic [1:0] {
    MODE_COARSE = 2'd0,
    MODE_TRACK  = 2'd1,
    MODE_HOLD   = 2'd2
  } trim_mode_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_phase_sampler.sv
module sar_phase_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic fb_clk,
  output logic lead_o
);
  logic                   cap_q;
  logic [SYNC_STAGES-1:0] sync_q;

  // bang-bang capture: feedback still low at reference edge => reference leads
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      cap_q  <= ~fb_clk;
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_q};
    end
  end

  assign lead_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
  parameter int DIV = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en_i)                     cnt_d = '0;
    else if (cnt_q == CW'(DIV-1))  cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == CW'(DIV-1));

  // R4
  tick_gap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sar_trim_seq.sv
module sar_trim_seq
  import sar_trim_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic         lock_i,
  input  logic         tick_i,
  input  logic         lead_i,
  output logic [W-1:0] code_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int PW = (W > 2) ? $clog2(W) : 1;

  trim_mode_e    mode_q, mode_d;
  logic [W-1:0]  code_q, code_d;
  logic [PW-1:0] ptr_q,  ptr_d;

  always_comb begin
    mode_d = mode_q;
    code_d = code_q;
    ptr_d  = ptr_q;
    if (!lock_i) begin
      mode_d = MODE_COARSE;
      code_d = '1;
      ptr_d  = '0;
    end else begin
      case (mode_q)
        MODE_COARSE: begin
          mode_d = MODE_TRACK;
          code_d = '1;
          ptr_d  = '0;
        end
        MODE_TRACK: begin
          if (tick_i) begin
            for (int b = 0; b < W; b++) begin
              if ((ptr_q != '0) && (b == W - int'(ptr_q)) && !lead_i)
                code_d[b] = 1'b1;
              if (b == W - 1 - int'(ptr_q))
                code_d[b] = 1'b0;
            end
            if (ptr_q == PW'(W-1)) mode_d = MODE_HOLD;
            else                   ptr_d  = ptr_q + 1'b1;
          end
        end
        MODE_HOLD: ;
        default: begin
          mode_d = MODE_COARSE;
          code_d = '1;
          ptr_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_COARSE;
      code_q <= '1;
      ptr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
      ptr_q  <= ptr_d;
    end
  end

  assign code_o = code_q;
  assign busy_o = (mode_q == MODE_TRACK);
  assign done_o = (mode_q == MODE_HOLD);

  // R8
  lock_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !lock_i |=> (code_o == '1) && !busy_o && !done_o);

  // R4
  hold_between_ticks_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lock_i && !tick_i) |=> $stable(code_o));

  // R7
  frozen_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done_o && lock_i) |=> $stable(code_o) && done_o);

  // R3
  start_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lock_i && mode_q == MODE_COARSE) |=> busy_o);

  // R7
  excl_flags_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

// File: rtl/sar_trim_ctrl.sv
module sar_trim_ctrl #(
  parameter int W   = 4,
  parameter int DIV = 16
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic         fb_clk,
  input  logic         locked_i,
  output logic [W-1:0] trim_code_o,
  output logic         busy_o,
  output logic         done_o
);
  logic rst_sn;
  logic lead;
  logic tick;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk    (ref_clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  sar_phase_sampler #(.SYNC_STAGES(2)) u_samp (
    .ref_clk (ref_clk),
    .rst_n   (rst_sn),
    .fb_clk  (fb_clk),
    .lead_o  (lead)
  );

  sar_tick_div #(.DIV(DIV)) u_div (
    .ref_clk (ref_clk),
    .rst_n   (rst_sn),
    .en_i    (busy_o),
    .tick_o  (tick)
  );

  sar_trim_seq #(.W(W)) u_seq (
    .ref_clk (ref_clk),
    .rst_n   (rst_sn),
    .lock_i  (locked_i),
    .tick_i  (tick),
    .lead_i  (lead),
    .code_o  (trim_code_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );
endmodule

// File: tb/tb_sar_trim_ctrl.sv
module tb_sar_trim_ctrl;
  localparam int P = 10;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       fb_clk;
  logic       locked_i;
  logic [3:0] trim_code_o;
  logic       busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int target = 0;
  bit force_lag = 1'b0;
  bit use_force = 1'b0;
  bit finished  = 1'b0;

  sar_trim_ctrl dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .fb_clk(fb_clk), .locked_i(locked_i),
    .trim_code_o(trim_code_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #(P/2) ref_clk = ~ref_clk;

  // feedback model: reference lags when code at or below the target
  function automatic bit lag_now();
    if (use_force) return force_lag;
    return (int'(trim_code_o) <= target);
  endfunction

  initial begin
    fb_clk = 1'b0;
    forever begin
      @(negedge ref_clk); #(P/4); fb_clk = lag_now();
      @(posedge ref_clk); #(P/8); fb_clk = 1'b1;
      #(P/8); fb_clk = 1'b0;
    end
  end

  function automatic logic [3:0] step_exp(int t, int k);
    logic [3:0] c = 4'hF;
    for (int i = 0; i < k; i++) begin
      if (i != 0 && int'(c) <= t) c[4-i] = 1'b1;
      c[3-i] = 1'b0;
    end
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // full search with step-by-step checks (R3 R4 R5 R7)
  task automatic run_search(int t);
    logic [3:0] held;
    target = t;
    @(negedge ref_clk); locked_i = 1'b1;
    @(posedge ref_clk); @(negedge ref_clk);
    chk("R3 busy on lock", busy_o, 1);
    for (int k = 1; k <= 4; k++) begin
      held = trim_code_o;
      repeat (15) @(posedge ref_clk);
      @(negedge ref_clk);
      chk("R4 stable before tick", trim_code_o, held);
      @(posedge ref_clk); @(negedge ref_clk);
      chk(k == 1 ? "R3 first step" : "R5 step code", trim_code_o, step_exp(t, k));
    end
    chk("R7 done", done_o, 1);
    chk("R7 busy low", busy_o, 0);
    chk("R7 lsb trial kept", trim_code_o[0], 0);
    held = trim_code_o;
    repeat (40) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R7 frozen", trim_code_o, held);
  endtask

  task automatic drop_lock();
    @(negedge ref_clk); locked_i = 1'b0;
    @(posedge ref_clk); @(negedge ref_clk);
    chk("R8 code", trim_code_o, 15);
    chk("R8 busy", busy_o, 0);
    chk("R8 done", done_o, 0);
  endtask

  initial begin
    #(P*150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; locked_i = 1'b0;
    #(P*3 + 2);
    chk("R1 code in reset", trim_code_o, 15);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    @(negedge ref_clk); rst_n = 1'b1;
    repeat (4) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R1 code after reset", trim_code_o, 15);

    // R2: no lock, both polarities
    use_force = 1'b1;
    for (int i = 0; i < 40; i++) begin
      force_lag = (i % 7) < 3;
      @(posedge ref_clk);
    end
    @(negedge ref_clk);
    chk("R2 code idle", trim_code_o, 15);
    chk("R2 busy idle", busy_o, 0);
    chk("R2 done idle", done_o, 0);
    use_force = 1'b0;

    // R6 directed sequence: pos, neg, pos
    run_search(4);
    chk("R6 final code", trim_code_o, 4'b0100);
    drop_lock();

    // R8: drop mid-search, then relock with full timing
    target = 9;
    @(negedge ref_clk); locked_i = 1'b1;
    repeat (25) @(posedge ref_clk);
    drop_lock();
    run_search(9);
    drop_lock();

    // corner targets and random ones
    run_search(0);  drop_lock();
    run_search(15); drop_lock();
    for (int n = 0; n < 10; n++) begin
      run_search(int'($urandom_range(0, 15)));
      drop_lock();
    end
    summary();
  end
endmodule